// File: doc/BRIEF.md
# Four-Operand Selector and Summing Register

This block chooses four 58-bit operands from a set of datapath sources and adds them into a registered 58-bit sum. A 9-bit selection word picks the source for each operand. The sources are a general operand, a concatenated wide operand, a cascade input, a rounding constant, an all-ones constant, the block's own registered sum fed back, and a pair of multiplier partial products. The four operands are then summed modulo 2^58 and registered. The selection word can change on any clock cycle, so a calculation sequence can reconfigure the datapath cycle by cycle.

Some codes depend on one another. The multiplier partial products must be chosen on the second and third operand slots together. One fourth-slot code, the wide-accumulate extension, is only allowed with fixed codes in the other three fields. Two fourth-slot codes apply an arithmetic right shift, and a build parameter sets its distance. When a selection is forbidden, the block raises a flag and drives the affected operand to zero. A build parameter decides whether the selection word passes through a pipeline register before it reaches the decoder.

Top module: `quad_operand_sum`

## Requirements
- R1: The selection word `opsel` splits as follows: bits [8:7] choose operand W, bits [6:4] choose operand Z, bits [3:2] choose operand Y and bits [1:0] choose operand X. For W, code 00 gives zero, 01 gives the fed-back sum `sum_q`, 10 gives `round_k` and 11 gives `c_opnd`.
- R2: For X, code 00 gives zero, 10 gives `sum_q`, 11 gives `ab_opnd`, and 01 gives the first partial product `pp_a`.
- R3: For Y, code 00 gives zero, 10 gives a 58-bit all-ones constant, 11 gives `c_opnd`, and 01 gives the second partial product `pp_b`.
- R4: The X code 01 and the Y code 01 are legal only when both fields hold 01. If only one field holds 01, `bad_combo` is 1 and that operand is zero.
- R5: When the multiplier pair is legal, a low `mul_neg` passes `pp_a` and `pp_b` through unchanged. A high `mul_neg` gives the two's complement negation of each, modulo 2^58.
- R6: For Z, code 000 gives zero, 001 gives `casc_in`, 010 gives `sum_q` and 011 gives `c_opnd`.
- R7: The Z code 100 gives `sum_q` only when W=00, Y=10 and X=00. With any other W, Y or X code, `bad_combo` is 1 and Z is zero.
- R8: The Z code 101 gives `casc_in` arithmetically shifted right, and code 110 gives `sum_q` arithmetically shifted right. The shift is 17 bits when NARROW_SHIFT=1 and 23 bits when NARROW_SHIFT=0.
- R9: The Z code 111 is forbidden: `bad_combo` is 1 and Z is zero.
- R10: `bad_combo` is 0 for every selection word that is not covered by R4, R7 or R9.
- R11: On each rising clock edge, `sum_q` takes the value (W+X+Y+Z) mod 2^58. While `rst` is high, it clears to zero on the edge.
- R12: With OPSEL_REG=1, a selection word applied before an edge steers the operands from that edge on, and reset clears the stored word to 0. With OPSEL_REG=0, the operands follow `opsel` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opsel | input | 9 | Operand selection word |
| c_opnd | input | 58 | General operand |
| ab_opnd | input | 58 | Concatenated wide operand |
| casc_in | input | 58 | Cascade input from a neighbouring slice |
| round_k | input | 58 | Rounding constant |
| pp_a | input | 58 | First multiplier partial product |
| pp_b | input | 58 | Second multiplier partial product |
| mul_neg | input | 1 | Negates both partial products when high |
| sum_q | output | 58 | Registered four-operand sum |
| w_op | output | 58 | Selected operand W |
| x_op | output | 58 | Selected operand X |
| y_op | output | 58 | Selected operand Y |
| z_op | output | 58 | Selected operand Z |
| bad_combo | output | 1 | Forbidden selection decoded |

## Verification
Feedback and reconfiguration can land in the same cycle: a new selection word routes `sum_q` onto one or more slots, while `sum_q` itself is taking the sum chosen by the previous word. The bench provokes this by changing the word every cycle, on one instance with the word registered and on one without it. A behavioural model tracks each instance's stored word and sum, and every operand, flag and sum is compared each cycle. A second pairing is a forbidden multiplier half together with a negate request in the same cycle. In that case the operand must read zero, not a negated product.

// File: rtl/qos_pkg.sv
package qos_pkg;

    localparam int DATA_W       = 58;
    localparam int SHIFT_NARROW = 17;
    localparam int SHIFT_WIDE   = 23;

    typedef struct packed {
        logic [1:0] w;
        logic [2:0] z;
        logic [1:0] y;
        logic [1:0] x;
    } opsel_t;

    localparam int OPSEL_W = $bits(opsel_t);

    typedef enum logic [1:0] {
        WS_ZERO = 2'b00,
        WS_FB   = 2'b01,
        WS_RND  = 2'b10,
        WS_C    = 2'b11
    } w_src_e;

    typedef enum logic [1:0] {
        XS_ZERO = 2'b00,
        XS_MUL  = 2'b01,
        XS_FB   = 2'b10,
        XS_AB   = 2'b11
    } x_src_e;

    typedef enum logic [1:0] {
        YS_ZERO = 2'b00,
        YS_MUL  = 2'b01,
        YS_ONES = 2'b10,
        YS_C    = 2'b11
    } y_src_e;

    typedef enum logic [2:0] {
        ZS_ZERO    = 3'b000,
        ZS_CASC    = 3'b001,
        ZS_FB      = 3'b010,
        ZS_C       = 3'b011,
        ZS_FB_EXT  = 3'b100,
        ZS_CASC_SH = 3'b101,
        ZS_FB_SH   = 3'b110
    } z_src_e;

    typedef struct packed {
        w_src_e w;
        x_src_e x;
        y_src_e y;
        z_src_e z;
        logic   x_bad;
        logic   y_bad;
        logic   z_bad;
    } route_t;

    function automatic logic mul_pair_ok(opsel_t s);
        return (s.x == 2'b01) && (s.y == 2'b01);
    endfunction

    function automatic logic ext_ok(opsel_t s);
        return (s.w == 2'b00) && (s.y == 2'b10) && (s.x == 2'b00);
    endfunction

endpackage

// File: rtl/qos_opsel_stage.sv
module qos_opsel_stage
    import qos_pkg::*;
#(
    parameter bit REGISTERED = 1'b1
) (
    input  logic   clk,
    input  logic   rst,
    input  opsel_t sel_in,
    output opsel_t sel_out
);

    opsel_t sel_q;

    always_ff @(posedge clk) begin
        if (rst) sel_q <= '0;
        else     sel_q <= sel_in;
    end

    assign sel_out = REGISTERED ? sel_q : sel_in;

endmodule

// File: rtl/qos_route_decode.sv
module qos_route_decode
    import qos_pkg::*;
(
    input  opsel_t sel,
    output route_t route,
    output logic   bad
);

    always_comb begin
        route   = '0;
        route.w = w_src_e'(sel.w);

        unique case (sel.x)
            2'b00: route.x = XS_ZERO;
            2'b01: begin
                if (mul_pair_ok(sel)) route.x = XS_MUL;
                else begin
                    route.x     = XS_ZERO;
                    route.x_bad = 1'b1;
                end
            end
            2'b10: route.x = XS_FB;
            default: route.x = XS_AB;
        endcase

        unique case (sel.y)
            2'b00: route.y = YS_ZERO;
            2'b01: begin
                if (mul_pair_ok(sel)) route.y = YS_MUL;
                else begin
                    route.y     = YS_ZERO;
                    route.y_bad = 1'b1;
                end
            end
            2'b10: route.y = YS_ONES;
            default: route.y = YS_C;
        endcase

        unique case (sel.z)
            3'b000: route.z = ZS_ZERO;
            3'b001: route.z = ZS_CASC;
            3'b010: route.z = ZS_FB;
            3'b011: route.z = ZS_C;
            3'b100: begin
                if (ext_ok(sel)) route.z = ZS_FB_EXT;
                else begin
                    route.z     = ZS_ZERO;
                    route.z_bad = 1'b1;
                end
            end
            3'b101: route.z = ZS_CASC_SH;
            3'b110: route.z = ZS_FB_SH;
            default: begin
                route.z     = ZS_ZERO;
                route.z_bad = 1'b1;
            end
        endcase
    end

    assign bad = route.x_bad | route.y_bad | route.z_bad;

endmodule

// File: rtl/qos_operand_mux.sv
module qos_operand_mux
    import qos_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int SHIFT = SHIFT_WIDE
) (
    input  route_t        route,
    input  logic [DW-1:0] c_opnd,
    input  logic [DW-1:0] ab_opnd,
    input  logic [DW-1:0] casc_in,
    input  logic [DW-1:0] round_k,
    input  logic [DW-1:0] pp_a,
    input  logic [DW-1:0] pp_b,
    input  logic          mul_neg,
    input  logic [DW-1:0] fb,
    output logic [DW-1:0] w_op,
    output logic [DW-1:0] x_op,
    output logic [DW-1:0] y_op,
    output logic [DW-1:0] z_op
);

    localparam logic [DW-1:0] ALL_ONES = '1;

    logic [DW-1:0] term_a, term_b, casc_sh, fb_sh;

    assign term_a  = mul_neg ? (DW'(0) - pp_a) : pp_a;
    assign term_b  = mul_neg ? (DW'(0) - pp_b) : pp_b;
    assign casc_sh = DW'($signed(casc_in) >>> SHIFT);
    assign fb_sh   = DW'($signed(fb) >>> SHIFT);

    always_comb begin
        unique case (route.w)
            WS_FB:   w_op = fb;
            WS_RND:  w_op = round_k;
            WS_C:    w_op = c_opnd;
            default: w_op = '0;
        endcase

        unique case (route.x)
            XS_MUL:  x_op = term_a;
            XS_FB:   x_op = fb;
            XS_AB:   x_op = ab_opnd;
            default: x_op = '0;
        endcase

        unique case (route.y)
            YS_MUL:  y_op = term_b;
            YS_ONES: y_op = ALL_ONES;
            YS_C:    y_op = c_opnd;
            default: y_op = '0;
        endcase

        case (route.z)
            ZS_CASC:    z_op = casc_in;
            ZS_FB:      z_op = fb;
            ZS_C:       z_op = c_opnd;
            ZS_FB_EXT:  z_op = fb;
            ZS_CASC_SH: z_op = casc_sh;
            ZS_FB_SH:   z_op = fb_sh;
            default:    z_op = '0;
        endcase
    end

endmodule

// File: rtl/qos_sum_reg.sv
module qos_sum_reg #(
    parameter int DW = 58
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] w_op,
    input  logic [DW-1:0] x_op,
    input  logic [DW-1:0] y_op,
    input  logic [DW-1:0] z_op,
    output logic [DW-1:0] sum_q
);

    logic [DW-1:0] pair_wx, pair_yz;

    assign pair_wx = w_op + x_op;
    assign pair_yz = y_op + z_op;

    always_ff @(posedge clk) begin
        if (rst) sum_q <= '0;
        else     sum_q <= pair_wx + pair_yz;
    end

endmodule

// File: rtl/quad_operand_sum.sv
module quad_operand_sum
    import qos_pkg::*;
#(
    parameter int DW           = DATA_W,
    parameter bit NARROW_SHIFT = 1'b0,
    parameter bit OPSEL_REG    = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [OPSEL_W-1:0] opsel,
    input  logic [DW-1:0]      c_opnd,
    input  logic [DW-1:0]      ab_opnd,
    input  logic [DW-1:0]      casc_in,
    input  logic [DW-1:0]      round_k,
    input  logic [DW-1:0]      pp_a,
    input  logic [DW-1:0]      pp_b,
    input  logic               mul_neg,
    output logic [DW-1:0]      sum_q,
    output logic [DW-1:0]      w_op,
    output logic [DW-1:0]      x_op,
    output logic [DW-1:0]      y_op,
    output logic [DW-1:0]      z_op,
    output logic               bad_combo
);

    localparam int Z_SHIFT = NARROW_SHIFT ? SHIFT_NARROW : SHIFT_WIDE;

    opsel_t sel_raw, sel_eff;
    route_t route;

    assign sel_raw = opsel_t'(opsel);

    qos_opsel_stage #(.REGISTERED(OPSEL_REG)) u_stage (
        .clk    (clk),
        .rst    (rst),
        .sel_in (sel_raw),
        .sel_out(sel_eff)
    );

    qos_route_decode u_decode (
        .sel  (sel_eff),
        .route(route),
        .bad  (bad_combo)
    );

    qos_operand_mux #(.DW(DW), .SHIFT(Z_SHIFT)) u_mux (
        .route  (route),
        .c_opnd (c_opnd),
        .ab_opnd(ab_opnd),
        .casc_in(casc_in),
        .round_k(round_k),
        .pp_a   (pp_a),
        .pp_b   (pp_b),
        .mul_neg(mul_neg),
        .fb     (sum_q),
        .w_op   (w_op),
        .x_op   (x_op),
        .y_op   (y_op),
        .z_op   (z_op)
    );

    qos_sum_reg #(.DW(DW)) u_sum (
        .clk  (clk),
        .rst  (rst),
        .w_op (w_op),
        .x_op (x_op),
        .y_op (y_op),
        .z_op (z_op),
        .sum_q(sum_q)
    );

endmodule

// File: rtl/qos_checker.sv
module qos_checker #(
    parameter int DW        = 58,
    parameter bit OPSEL_REG = 1'b1
) (
    input logic          clk,
    input logic          rst,
    input logic [8:0]    sel_raw,
    input logic [8:0]    sel_eff,
    input logic [DW-1:0] pp_a,
    input logic [DW-1:0] pp_b,
    input logic          mul_neg,
    input logic [DW-1:0] sum_q,
    input logic [DW-1:0] w_op,
    input logic [DW-1:0] x_op,
    input logic [DW-1:0] y_op,
    input logic [DW-1:0] z_op,
    input logic          bad_combo
);

    logic [DW-1:0] op_total;
    assign op_total = w_op + x_op + y_op + z_op;

    // R11
    a_r11_sum_follows: assert property (@(posedge clk) disable iff (rst)
        !rst |=> sum_q == $past(op_total));

    // R4
    a_r4_lone_x_mul: assert property (@(posedge clk) disable iff (rst)
        (sel_eff[1:0] == 2'b01 && sel_eff[3:2] != 2'b01) |-> (bad_combo && x_op == '0));

    // R4
    a_r4_lone_y_mul: assert property (@(posedge clk) disable iff (rst)
        (sel_eff[3:2] == 2'b01 && sel_eff[1:0] != 2'b01) |-> (bad_combo && y_op == '0));

    // R5
    a_r5_negated_pair: assert property (@(posedge clk) disable iff (rst)
        (sel_eff[3:0] == 4'b0101 && mul_neg) |-> ((DW'(x_op + pp_a) == '0) && (DW'(y_op + pp_b) == '0)));

    // R9
    a_r9_z_forbidden: assert property (@(posedge clk) disable iff (rst)
        (sel_eff[6:4] == 3'b111) |-> (bad_combo && z_op == '0));

    // R7
    a_r7_ext_guard: assert property (@(posedge clk) disable iff (rst)
        (sel_eff[6:4] == 3'b100 && sel_eff[8:7] != 2'b00) |-> (bad_combo && z_op == '0));

    generate
        if (OPSEL_REG) begin : g_reg_chk
            // R12
            a_r12_sel_delayed: assert property (@(posedge clk) disable iff (rst)
                !rst |=> sel_eff == $past(sel_raw));
        end else begin : g_comb_chk
            // R12
            a_r12_sel_direct: assert property (@(posedge clk) disable iff (rst)
                sel_eff == sel_raw);
        end
    endgenerate

endmodule

bind quad_operand_sum qos_checker #(.DW(DW), .OPSEL_REG(OPSEL_REG)) u_qos_checker (
    .clk      (clk),
    .rst      (rst),
    .sel_raw  (opsel),
    .sel_eff  (sel_eff),
    .pp_a     (pp_a),
    .pp_b     (pp_b),
    .mul_neg  (mul_neg),
    .sum_q    (sum_q),
    .w_op     (w_op),
    .x_op     (x_op),
    .y_op     (y_op),
    .z_op     (z_op),
    .bad_combo(bad_combo)
);

// File: tb/quad_operand_sum_bench.sv
module quad_operand_sum_bench;

    localparam int DW = 58;

    logic          clk = 1'b0;
    logic          rst;
    logic [8:0]    opsel;
    logic [DW-1:0] c_opnd, ab_opnd, casc_in, round_k, pp_a, pp_b;
    logic          mul_neg;

    logic [DW-1:0] sa, wa, xa, ya, za;
    logic [DW-1:0] sb, wb, xb, yb, zb;
    logic          bada, badb;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [DW-1:0] sa_ref, sb_ref;
    logic [8:0]    selb_ref;

    always #5 clk = ~clk;

    // combinational selection word, wide shift
    quad_operand_sum #(.DW(DW), .NARROW_SHIFT(1'b0), .OPSEL_REG(1'b0)) u_quad_operand_sum (
        .clk(clk), .rst(rst), .opsel(opsel), .c_opnd(c_opnd), .ab_opnd(ab_opnd),
        .casc_in(casc_in), .round_k(round_k), .pp_a(pp_a), .pp_b(pp_b), .mul_neg(mul_neg),
        .sum_q(sa), .w_op(wa), .x_op(xa), .y_op(ya), .z_op(za), .bad_combo(bada)
    );

    // registered selection word, narrow shift
    quad_operand_sum #(.DW(DW), .NARROW_SHIFT(1'b1), .OPSEL_REG(1'b1)) u_quad_operand_sum_b (
        .clk(clk), .rst(rst), .opsel(opsel), .c_opnd(c_opnd), .ab_opnd(ab_opnd),
        .casc_in(casc_in), .round_k(round_k), .pp_a(pp_a), .pp_b(pp_b), .mul_neg(mul_neg),
        .sum_q(sb), .w_op(wb), .x_op(xb), .y_op(yb), .z_op(zb), .bad_combo(badb)
    );

    function automatic logic [DW-1:0] rnd_word();
        logic [63:0] t;
        t = {$urandom(), $urandom()};
        return t[DW-1:0];
    endfunction

    function automatic logic [DW-1:0] sra(logic [DW-1:0] v, int n);
        logic [DW-1:0] r;
        r = v;
        for (int i = 0; i < n; i++) r = {r[DW-1], r[DW-1:1]};
        return r;
    endfunction

    task automatic model(input logic [8:0] m, input logic [DW-1:0] fb, input int sh,
                         output logic [DW-1:0] ew, output logic [DW-1:0] ex,
                         output logic [DW-1:0] ey, output logic [DW-1:0] ez,
                         output logic eb);
        logic pair;
        pair = (m[1:0] == 2'd1) && (m[3:2] == 2'd1);
        eb = 1'b0;
        case (m[8:7])
            2'd0: ew = '0;
            2'd1: ew = fb;
            2'd2: ew = round_k;
            default: ew = c_opnd;
        endcase
        case (m[1:0])
            2'd0: ex = '0;
            2'd1: begin
                ex = pair ? (mul_neg ? -pp_a : pp_a) : '0;
                if (!pair) eb = 1'b1;
            end
            2'd2: ex = fb;
            default: ex = ab_opnd;
        endcase
        case (m[3:2])
            2'd0: ey = '0;
            2'd1: begin
                ey = pair ? (mul_neg ? -pp_b : pp_b) : '0;
                if (!pair) eb = 1'b1;
            end
            2'd2: ey = '1;
            default: ey = c_opnd;
        endcase
        case (m[6:4])
            3'd0: ez = '0;
            3'd1: ez = casc_in;
            3'd2: ez = fb;
            3'd3: ez = c_opnd;
            3'd4: begin
                if (m[8:7] == 2'd0 && m[3:2] == 2'd2 && m[1:0] == 2'd0) ez = fb;
                else begin
                    ez = '0;
                    eb = 1'b1;
                end
            end
            3'd5: ez = sra(casc_in, sh);
            3'd6: ez = sra(fb, sh);
            default: begin
                ez = '0;
                eb = 1'b1;
            end
        endcase
    endtask

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // One clock: check operands before the edge, update the model at the edge, check sums after.
    task automatic step(input bit check_ops);
        logic [DW-1:0] ew, ex, ey, ez, fw, fx, fy, fz;
        logic eb, fbad;
        #1;
        model(opsel, sa_ref, 23, ew, ex, ey, ez, eb);
        model(selb_ref, sb_ref, 17, fw, fx, fy, fz, fbad);
        if (check_ops) begin
            chk("R1 W operand", wa, ew);
            chk("R2/R4/R5 X operand", xa, ex);
            chk("R3/R4/R5 Y operand", ya, ey);
            chk("R6/R7/R8/R9 Z operand", za, ez);
            chk("R4/R7/R9/R10 flag", DW'(bada), DW'(eb));
            chk("R12 W operand, stored word", wb, fw);
            chk("R12 X operand, stored word", xb, fx);
            chk("R12 Y operand, stored word", yb, fy);
            chk("R12/R8 Z operand, narrow shift", zb, fz);
            chk("R12 flag, stored word", DW'(badb), DW'(fbad));
        end
        @(posedge clk);
        if (rst) begin
            sa_ref   = '0;
            sb_ref   = '0;
            selb_ref = '0;
        end else begin
            sa_ref   = ew + ex + ey + ez;
            sb_ref   = fw + fx + fy + fz;
            selb_ref = opsel;
        end
        @(negedge clk);
        chk("R11 sum", sa, sa_ref);
        chk("R11/R12 sum, stored word", sb, sb_ref);
    endtask

    task automatic load_data();
        c_opnd  = rnd_word();
        ab_opnd = rnd_word();
        casc_in = rnd_word();
        round_k = rnd_word();
        pp_a    = rnd_word();
        pp_b    = rnd_word();
    endtask

    // {W, Z, Y, X}
    localparam logic [8:0] DIRECTED [22] = '{
        {2'b00, 3'b000, 2'b00, 2'b00},
        {2'b01, 3'b000, 2'b00, 2'b11},
        {2'b10, 3'b000, 2'b11, 2'b00},
        {2'b11, 3'b001, 2'b00, 2'b00},
        {2'b00, 3'b000, 2'b01, 2'b01},
        {2'b00, 3'b000, 2'b01, 2'b01},
        {2'b00, 3'b000, 2'b00, 2'b01},
        {2'b00, 3'b000, 2'b01, 2'b00},
        {2'b00, 3'b000, 2'b10, 2'b01},
        {2'b01, 3'b010, 2'b10, 2'b10},
        {2'b00, 3'b011, 2'b11, 2'b10},
        {2'b00, 3'b100, 2'b10, 2'b00},
        {2'b01, 3'b100, 2'b10, 2'b00},
        {2'b00, 3'b100, 2'b00, 2'b00},
        {2'b00, 3'b100, 2'b10, 2'b11},
        {2'b00, 3'b101, 2'b00, 2'b00},
        {2'b00, 3'b110, 2'b00, 2'b00},
        {2'b11, 3'b110, 2'b01, 2'b01},
        {2'b00, 3'b111, 2'b00, 2'b00},
        {2'b10, 3'b111, 2'b10, 2'b11},
        {2'b00, 3'b101, 2'b01, 2'b01},
        {2'b00, 3'b000, 2'b00, 2'b00}
    };

    initial begin
        rst     = 1'b1;
        opsel   = 9'h1ff;
        mul_neg = 1'b0;
        load_data();
        sa_ref   = '0;
        sb_ref   = '0;
        selb_ref = '0;
        // R11 reset clears the sums; R12 reset clears the stored word
        step(1'b0);
        step(1'b0);
        rst = 1'b0;
        opsel = '0;
        load_data();
        step(1'b1);
        for (int i = 0; i < 22; i++) begin
            opsel   = DIRECTED[i];
            mul_neg = (i % 2) == 1;
            load_data();
            if (i == 15 || i == 20) casc_in[DW-1] = 1'b1;
            step(1'b1);
        end
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r;
            r       = $urandom();
            opsel   = r[8:0];
            mul_neg = r[9];
            if (r[12:10] == 3'd0) opsel[3:0] = 4'b0101;
            load_data();
            step(1'b1);
        end
        rst = 1'b1;
        step(1'b0);
        rst = 1'b0;
        opsel = '0;
        step(1'b1);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule